// File: doc/BRIEF.md
# Timer compare interrupt unit

This block keeps the time base that one processor core uses to raise timer interrupts. It has a per-core tick counter that runs freely from reset, and a view of a system-wide time that every core shares. The system time is not stored. The block holds an offset against an external 63-bit time input, so a write sets the value that later reads observe. Three compare registers sit against these counts: one against the core tick, and two (normal and hypervisor level) against the system tick. A compare register that is armed raises a one-cycle interrupt pulse on its own output when its count equals its compare value.

Software reaches the registers through a single-cycle addressed port. Each access carries a privilege flag, and read data returns in the same cycle. Accesses that privilege does not allow are refused on one of two fault outputs and change no state. Every write to a compare register decides again whether its event is pending. A write with the disable bit set cancels the event. A write with the disable bit clear arms the event only if the compare value still lies ahead of the current count.

Top module: `tcu_timer_cmp`

## Requirements
- R1: After reset, each compare register reads as 0x8000_0000_0000_0000 (disable bit 63 set, compare value 0). The non-privileged-trap bit of both the core tick and the system tick is 1.
- R2: Address 0 reads the core tick as {trap bit (bit 63), count (bits 62:0)}. The count is 0 in the first cycle after reset is released and rises by one every clock.
- R3: A privileged write to address 1 stores the offset (time input minus written bits 62:0) and takes written bit 63 as the system-tick trap bit.
- R4: A read of address 1 returns {trap bit, (time input minus offset) bits 62:0}. If the trap bit is 1, the read instead asserts fault_action and returns 0.
- R5: A non-privileged read or write of addresses 2 to 4, or a non-privileged write of address 1, asserts fault_opcode, returns 0 and changes no register.
- R6: A privileged compare write with bit 63 set cancels any pending event of that register.
- R7: A privileged compare write with bit 63 clear arms the event only when the written bits 62:0 are greater than that register's count in the write cycle.
- R8: An armed event fires once, in the cycle its count equals its compare value. Its own irq output is high for exactly the next cycle, and the event is then disarmed. A count that jumps past the value does not fire.
- R9: The map is address 0 core tick, 1 system tick, 2 core-tick compare, 3 system-tick compare and 4 hypervisor system-tick compare. Other addresses read 0 without fault, and writes to them or to address 0 change nothing.
- R10: A compare write in the same cycle as that register's match takes precedence, and the old event does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_time | input | 63 | Shared system time base |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 64 | Write data |
| acc_priv | input | 1 | 1 = privileged access |
| acc_rdata | output | 64 | Read data, same cycle |
| fault_opcode | output | 1 | Access refused for lack of privilege |
| fault_action | output | 1 | System-tick read refused by its trap bit |
| irq_tick | output | 1 | Core-tick compare pulse |
| irq_stick | output | 1 | System-tick compare pulse |
| irq_hstick | output | 1 | Hypervisor system-tick compare pulse |

## Verification
The bench aims compare values at a count exactly one step ahead, at the current count itself, and at the current count plus a few cycles. A design that tested "greater or equal" would fire on a stale value, and one that compared with ≥ at match time would fire when the system time jumps past the target. It cancels a pending event just before it would fire, and rewrites a compare register in the very cycle of its match. A design that gave the old event priority there would emit a pulse. It also exercises refused writes followed by read-back, system-tick writes with either trap-bit value, and unmapped addresses. Each of these would expose a design that lets a faulting access change state or that places the trap bit wrongly.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
    localparam int NUM_CMP      = 3;
    localparam int ADR_TICK     = 0;
    localparam int ADR_STICK    = 1;
    localparam int ADR_CMP_BASE = 2;
    localparam int CMP_TICK     = 0;
    localparam int CMP_STICK    = 1;
    localparam int CMP_HSTICK   = 2;
endpackage

// File: rtl/tcu_cmp_slot.sv
module tcu_cmp_slot #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-2:0] count,
    output logic [DATA_W-1:0] cfg,
    output logic              irq
);
    localparam int VAL_W = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              armed;
        logic              irq;
    } slot_st_t;

    slot_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (wr_en) begin
            // a write re-decides the event and wins over a match
            s_d.cfg   = wr_data;
            s_d.armed = !wr_data[DATA_W-1] && (wr_data[VAL_W-1:0] > count);
        end else if (s_q.armed && (count == s_q.cfg[VAL_W-1:0])) begin
            s_d.irq   = 1'b1;
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg   <= {1'b1, {VAL_W{1'b0}}};
            s_q.armed <= 1'b0;
            s_q.irq   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg = s_q.cfg;
    assign irq = s_q.irq;
endmodule

// File: rtl/tcu_timer_cmp.sv
module tcu_timer_cmp
    import tcu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-2:0] sys_time,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_priv,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              fault_opcode,
    output logic              fault_action,
    output logic              irq_tick,
    output logic              irq_stick,
    output logic              irq_hstick
);
    localparam int CNT_W = DATA_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] tick_cnt;
        logic             tick_npt;
        logic [CNT_W-1:0] stick_off;
        logic             stick_npt;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [CNT_W-1:0]                  stick_cnt;
    logic                              sel_tick, sel_stick, any_cmp;
    logic                              wr_ok, rd_ok;
    logic [NUM_CMP-1:0]                sel_cmp, cmp_we, cmp_irq;
    logic [NUM_CMP-1:0][DATA_W-1:0]    cmp_cfg;
    logic [NUM_CMP-1:0][CNT_W-1:0]     cmp_cnt;

    // address decode
    assign sel_tick  = (acc_addr == ADDR_W'(ADR_TICK));
    assign sel_stick = (acc_addr == ADDR_W'(ADR_STICK));
    assign any_cmp   = |sel_cmp;

    // privilege checks
    assign fault_opcode = acc_valid && !acc_priv && (any_cmp || (acc_write && sel_stick));
    assign fault_action = acc_valid && !acc_write && sel_stick && st_q.stick_npt;
    assign wr_ok        = acc_valid && acc_write && !fault_opcode;
    assign rd_ok        = acc_valid && !acc_write && !fault_opcode && !fault_action;

    // system tick seen through its offset
    assign stick_cnt = sys_time - st_q.stick_off;

    always_comb begin
        st_d          = st_q;
        st_d.tick_cnt = st_q.tick_cnt + 1'b1;
        if (wr_ok && sel_stick) begin
            st_d.stick_off = sys_time - acc_wdata[CNT_W-1:0];
            st_d.stick_npt = acc_wdata[DATA_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tick_cnt  <= '0;
            st_q.tick_npt  <= 1'b1;
            st_q.stick_off <= '0;
            st_q.stick_npt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        acc_rdata = '0;
        if (rd_ok) begin
            if (sel_tick)  acc_rdata = {st_q.tick_npt, st_q.tick_cnt};
            if (sel_stick) acc_rdata = {st_q.stick_npt, stick_cnt};
            for (int i = 0; i < NUM_CMP; i++) begin
                if (sel_cmp[i]) acc_rdata = cmp_cfg[i];
            end
        end
    end

    // compare slots: slot 0 follows the core tick, the rest the system tick
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_slot
        assign sel_cmp[g] = (acc_addr == ADDR_W'(ADR_CMP_BASE + g));
        assign cmp_we[g]  = wr_ok && sel_cmp[g];
        if (g == CMP_TICK) begin : g_core
            assign cmp_cnt[g] = st_q.tick_cnt;
        end else begin : g_sys
            assign cmp_cnt[g] = stick_cnt;
        end
        tcu_cmp_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cmp_we[g]),
            .wr_data (acc_wdata),
            .count   (cmp_cnt[g]),
            .cfg     (cmp_cfg[g]),
            .irq     (cmp_irq[g])
        );
    end

    assign irq_tick   = cmp_irq[CMP_TICK];
    assign irq_stick  = cmp_irq[CMP_STICK];
    assign irq_hstick = cmp_irq[CMP_HSTICK];
endmodule

// File: rtl/tcu_timer_cmp_chk.sv
module tcu_timer_cmp_chk #(
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 3,
    parameter int NUM_CMP = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           acc_valid,
    input logic                           acc_write,
    input logic [ADDR_W-1:0]              acc_addr,
    input logic [DATA_W-1:0]              acc_wdata,
    input logic                           acc_priv,
    input logic [DATA_W-1:0]              acc_rdata,
    input logic                           fault_opcode,
    input logic                           fault_action,
    input logic [NUM_CMP-1:0]             cmp_irq,
    input logic [NUM_CMP-1:0][DATA_W-1:0] cmp_cfg
);
    // R5
    nonpriv_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_priv) |=> $stable(cmp_cfg));

    // R5
    opcode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_opcode |-> (acc_rdata == '0));

    // R4
    action_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_action |-> (acc_rdata == '0));

    // R8
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq[0] |=> !cmp_irq[0]);

    // R8
    stick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq[1] |=> !cmp_irq[1]);

    // R8
    hstick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq[2] |=> !cmp_irq[2]);

    // R6
    tick_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_priv && acc_addr == ADDR_W'(2) && acc_wdata[DATA_W-1])
        |=> ##1 !cmp_irq[0]);
endmodule

bind tcu_timer_cmp tcu_timer_cmp_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_CMP(tcu_pkg::NUM_CMP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .acc_wdata   (acc_wdata),
    .acc_priv    (acc_priv),
    .acc_rdata   (acc_rdata),
    .fault_opcode(fault_opcode),
    .fault_action(fault_action),
    .cmp_irq     (cmp_irq),
    .cmp_cfg     (cmp_cfg)
);

// File: tb/tcu_timer_cmp_tb.sv
module tcu_timer_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [62:0] sys_time = '0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic        fault_opcode, fault_action, irq_tick, irq_stick, irq_hstick;

    always #10 clk = ~clk;

    tcu_timer_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_priv(acc_priv), .acc_rdata(acc_rdata),
        .fault_opcode(fault_opcode), .fault_action(fault_action),
        .irq_tick(irq_tick), .irq_stick(irq_stick), .irq_hstick(irq_hstick)
    );

    // reference model state
    logic [62:0] m_tick, m_off, stime;
    logic        m_snpt;
    logic [63:0] m_cfg [3];
    bit          m_arm [3];
    bit          m_irq [3];
    int          seen  [3];
    int          vec = 0, bad = 0;
    bit          done = 1'b0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [62:0] mcount(int i);
        return (i == 0) ? m_tick : (stime - m_off);
    endfunction

    task automatic step(bit v, bit w, logic [2:0] a, logic [63:0] d, bit p, string req);
        bit          fop, fact;
        logic [63:0] rexp;
        logic [62:0] cnt [3];
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d; acc_priv = p;
        sys_time  = stime;
        #1;
        fop  = v && !p && ((a inside {3'd2, 3'd3, 3'd4}) || (w && a == 3'd1));
        fact = v && !w && a == 3'd1 && m_snpt;
        rexp = '0;
        if (v && !w && !fop && !fact) begin
            case (a)
                3'd0: rexp = {1'b1, m_tick};
                3'd1: rexp = {m_snpt, stime - m_off};
                3'd2, 3'd3, 3'd4: rexp = m_cfg[a - 3'd2];
                default: rexp = '0;
            endcase
        end
        if (v) begin
            chk({req, " fault_opcode"}, {63'd0, fault_opcode}, {63'd0, fop});
            chk({req, " fault_action"}, {63'd0, fault_action}, {63'd0, fact});
            if (!w) chk({req, " rdata"}, acc_rdata, rexp);
        end
        @(posedge clk);
        for (int i = 0; i < 3; i++) cnt[i] = mcount(i);
        for (int i = 0; i < 3; i++) begin
            m_irq[i] = 1'b0;
            if (v && w && p && a == 3'(2 + i)) begin
                m_cfg[i] = d;
                m_arm[i] = !d[63] && (d[62:0] > cnt[i]);
            end else if (m_arm[i] && cnt[i] == m_cfg[i][62:0]) begin
                m_irq[i] = 1'b1;
                m_arm[i] = 1'b0;
            end
        end
        if (v && w && p && a == 3'd1) begin
            m_off  = stime - d[62:0];
            m_snpt = d[63];
        end
        m_tick = m_tick + 1'b1;
        stime  = stime + 1'b1;
        @(negedge clk);
        chk("R8 irq", {61'd0, irq_hstick, irq_stick, irq_tick},
            {61'd0, m_irq[2], m_irq[1], m_irq[0]});
        seen[0] += int'(irq_tick);
        seen[1] += int'(irq_stick);
        seen[2] += int'(irq_hstick);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 3'd0, '0, 1'b0, "idle");
    endtask

    task automatic clr_seen();
        for (int i = 0; i < 3; i++) seen[i] = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            vec++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        m_tick = '0; m_off = '0; m_snpt = 1'b1; stime = 63'd1000;
        for (int i = 0; i < 3; i++) begin
            m_cfg[i] = 64'h8000_0000_0000_0000; m_arm[i] = 1'b0; m_irq[i] = 1'b0;
        end
        clr_seen();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: reset state
        step(1, 0, 3'd0, '0, 1, "R2 tick read at reset");
        step(1, 0, 3'd2, '0, 1, "R1 tick cmp reset");
        step(1, 0, 3'd3, '0, 1, "R1 stick cmp reset");
        step(1, 0, 3'd4, '0, 1, "R1 hstick cmp reset");
        step(1, 0, 3'd1, '0, 1, "R1 R4 stick trap at reset");
        idle(3);
        step(1, 0, 3'd0, '0, 0, "R2 tick counting");

        // R5: refused accesses
        step(1, 0, 3'd3, '0, 0, "R5 nonpriv cmp read");
        step(1, 1, 3'd2, 64'd50, 0, "R5 nonpriv cmp write");
        step(1, 0, 3'd2, '0, 1, "R5 cmp unchanged");
        step(1, 1, 3'd1, 64'd7, 0, "R5 nonpriv stick write");
        step(1, 0, 3'd1, '0, 1, "R5 stick still trapped");

        // R3 R4: system tick offset
        step(1, 1, 3'd1, 64'h100, 1, "R3 stick write");
        step(1, 0, 3'd1, '0, 0, "R3 R4 stick read");
        idle(2);
        step(1, 0, 3'd1, '0, 1, "R4 stick advances");
        step(1, 1, 3'd1, 64'h8000_0000_0000_0040, 1, "R3 stick write trap");
        step(1, 0, 3'd1, '0, 1, "R4 stick trap read");
        step(1, 1, 3'd1, 64'h200, 1, "R3 stick rewrite");

        // R7 R8: core tick compare fires once
        clr_seen();
        step(1, 1, 3'd2, {1'b0, m_tick + 63'd6}, 1, "R7 arm tick");
        idle(9);
        chk("R8 tick fired once", 64'(seen[0]), 64'd1);

        // R7: value equal to count does not arm
        clr_seen();
        step(1, 1, 3'd2, {1'b0, m_tick}, 1, "R7 equal not armed");
        idle(4);
        step(1, 1, 3'd2, {1'b0, m_tick + 63'd1}, 1, "R7 next count armed");
        idle(3);
        chk("R7 tick pulses", 64'(seen[0]), 64'd1);

        // R6: cancel pending event
        clr_seen();
        step(1, 1, 3'd2, {1'b0, m_tick + 63'd6}, 1, "R6 arm");
        idle(2);
        step(1, 1, 3'd2, {1'b1, m_tick + 63'd4}, 1, "R6 cancel");
        idle(8);
        chk("R6 no pulse after cancel", 64'(seen[0]), 64'd0);

        // R10: write in the match cycle wins
        clr_seen();
        step(1, 1, 3'd2, {1'b0, m_tick + 63'd3}, 1, "R10 arm");
        idle(2);
        step(1, 1, 3'd2, 64'h8000_0000_0000_0000, 1, "R10 write at match");
        idle(4);
        chk("R10 no pulse", 64'(seen[0]), 64'd0);

        // R8: system-tick compares on their own outputs
        clr_seen();
        step(1, 1, 3'd3, {1'b0, stime - m_off + 63'd4}, 1, "R7 arm stick");
        idle(6);
        chk("R8 stick fired once", 64'(seen[1]), 64'd1);
        chk("R8 tick quiet", 64'(seen[0]), 64'd0);
        clr_seen();
        step(1, 1, 3'd4, {1'b0, stime - m_off + 63'd5}, 1, "R7 arm hstick");
        idle(7);
        chk("R8 hstick fired once", 64'(seen[2]), 64'd1);
        chk("R8 stick quiet", 64'(seen[1]), 64'd0);

        // R8: time jumps past the value, no pulse
        clr_seen();
        step(1, 1, 3'd4, {1'b0, stime - m_off + 63'd3}, 1, "R7 arm hstick jump");
        stime = stime + 63'd20;
        idle(4);
        chk("R8 jump no pulse", 64'(seen[2]), 64'd0);

        // R9: unmapped and read-only addresses
        step(1, 0, 3'd5, '0, 1, "R9 unmapped read");
        step(1, 0, 3'd7, '0, 0, "R9 unmapped nonpriv read");
        step(1, 1, 3'd0, 64'd5, 1, "R9 tick write ignored");
        step(1, 1, 3'd6, 64'd5, 1, "R9 unmapped write");
        step(1, 0, 3'd0, '0, 0, "R9 tick unchanged");
        step(1, 0, 3'd4, '0, 1, "R9 hstick cfg");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule